// File: doc/BRIEF.md
# External Bus Idle-State Cycle Sequencer

This block steps the external memory interface through its bus states for four external memory blocks. In the multiplexed address/data mode a cycle runs T1, T2, T3; in the separate-bus mode it runs T1, T2. A read to a memory block whose enable bit is set gets one extra idle state (TI) at the end of the cycle. The idle state gives a slow device time to stop driving the data lines before the next cycle begins. A write never gets an idle state.

A 16-bit cycle control register holds one idle-enable bit per memory block. Every other bit of the register is fixed. The CPU side presents one request at a time: an address, a direction and a size, plus a flag that marks internal-area accesses. The sequencer ignores internal accesses. The bus mode is a static input, captured while reset is held.

Top module: `ext_bus_idle_seq`

## Requirements
- R1: In multiplexed mode (mode input 1 during reset) a cycle runs phases T1, T2, T3 on consecutive clocks. An inserted idle state TI comes directly after T3. Phase codes on `bus_phase_o`: 0 idle, 1 T1, 2 T2, 3 T3, 4 TI.
- R2: In separate mode (mode input 0 during reset) a cycle runs T1, T2. An inserted TI comes directly after T2, and T3 never appears.
- R3: A write cycle never contains TI, whatever the register holds.
- R4: Register bits 1, 3, 5 and 7 enable idle insertion for memory blocks 0, 1, 2 and 3. A bit value of 1 inserts TI on reads to that block and 0 omits it.
- R5: After reset the register reads 0xAAAA, so reads to every block get TI.
- R6: Bits 9, 11, 13 and 15 always read 1. Bits 0, 2, 4, 6, 8, 10, 12 and 14 always read 0. Writes to these bits have no effect, and the register is written only as a whole 16-bit word.
- R7: A request with the internal flag set starts no bus cycle. The phase stays 0 and ready stays high.
- R8: Address bits [25:24] select the memory block whose enable bit applies.
- R9: `done_o` pulses for one clock in the final state of a cycle: T3 or T2 when no idle follows, TI when one does. The block is ready again in the next clock, and it accepts no request until then.
- R10: The mode is taken only while reset is held. Changing the mode input later does not change the cycle shape.
- R11: `bus_rd_o` is high in T2 and T3 of a read, and `bus_wr_o` in T2 and T3 of a write. Neither strobe is high in T1 or TI, and the two are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mux_mode_i | input | 1 | 1 multiplexed, 0 separate; captured during reset |
| req_valid_i | input | 1 | Request present |
| req_addr_i | input | 32 | Request address |
| req_write_i | input | 1 | 1 write, 0 read |
| req_size_i | input | 2 | Access size code, carried to the bus |
| req_internal_i | input | 1 | Access targets an internal area |
| req_ready_o | output | 1 | Sequencer idle, request accepted |
| cfg_we_i | input | 1 | Full-word write to the cycle control register |
| cfg_wdata_i | input | 16 | Register write data |
| cfg_rdata_o | output | 16 | Register read data |
| bus_phase_o | output | 3 | Current bus phase code |
| bus_addr_o | output | 32 | Address of the cycle in progress |
| bus_write_o | output | 1 | Direction of the cycle in progress |
| bus_size_o | output | 2 | Size of the cycle in progress |
| bus_rd_o | output | 1 | Read strobe |
| bus_wr_o | output | 1 | Write strobe |
| done_o | output | 1 | Last state of the cycle |

## Verification
The bench sends writes to blocks whose idle bit is set. A design that ignored the direction would show a TI and one extra cycle. It enables a single block and reads from all four. A wrong bit-to-block mapping or the wrong address slice would put TI on the wrong block. It writes ones into the fixed-zero positions and zeros into the fixed-one positions. A design that stored them would read back a changed word. It flips the mode input after reset and checks that a miscaptured mode changes the cycle length. It also sends internal requests, which must not start a cycle or lower ready.

// File: rtl/ebis_pkg.sv
package ebis_pkg;
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_T1   = 3'd1,
    PH_T2   = 3'd2,
    PH_T3   = 3'd3,
    PH_TI   = 3'd4
  } bus_phase_e;
endpackage

// File: rtl/ebis_cfg_reg.sv
module ebis_cfg_reg #(
  parameter int REG_W = 16,
  parameter int N_BLK = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o,
  output logic [N_BLK-1:0] idle_en_o
);
  logic [N_BLK-1:0] en_q;

  // only the odd low bits are storage; all others are constants
  for (genvar b = 0; b < N_BLK; b++) begin : g_en
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   en_q[b] <= 1'b1;
      else if (we_i) en_q[b] <= wdata_i[2*b+1];
    end
  end

  for (genvar i = 0; i < REG_W; i++) begin : g_rd
    if (i % 2 == 0) begin : g_zero
      assign rdata_o[i] = 1'b0;
    end else if (i < 2 * N_BLK) begin : g_var
      assign rdata_o[i] = en_q[i/2];
    end else begin : g_one
      assign rdata_o[i] = 1'b1;
    end
  end

  assign idle_en_o = en_q;
endmodule

// File: rtl/ebis_blk_dec.sv
module ebis_blk_dec #(
  parameter int ADDR_W  = 32,
  parameter int N_BLK   = 4,
  parameter int BLK_LSB = 24
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              write_i,
  input  logic [N_BLK-1:0]  idle_en_i,
  output logic              idle_req_o
);
  localparam int BLK_W = $clog2(N_BLK);
  logic [BLK_W-1:0] blk;

  assign blk        = addr_i[BLK_LSB +: BLK_W];
  assign idle_req_o = !write_i && idle_en_i[blk];
endmodule

// File: rtl/ebis_seq.sv
module ebis_seq
  import ebis_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       mux_i,
  input  logic       start_i,
  input  logic       idle_req_i,
  output bus_phase_e phase_o,
  output logic       ready_o,
  output logic       done_o
);
  bus_phase_e ph_q, ph_d;
  logic       idle_q;

  always_comb begin
    ph_d = ph_q;
    unique case (ph_q)
      PH_IDLE: if (start_i) ph_d = PH_T1;
      PH_T1:   ph_d = PH_T2;
      PH_T2:   ph_d = mux_i ? PH_T3 : (idle_q ? PH_TI : PH_IDLE);
      PH_T3:   ph_d = idle_q ? PH_TI : PH_IDLE;
      PH_TI:   ph_d = PH_IDLE;
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= PH_IDLE;
      idle_q <= 1'b0;
    end else begin
      ph_q <= ph_d;
      if (ph_q == PH_IDLE && start_i) idle_q <= idle_req_i;
    end
  end

  assign phase_o = ph_q;
  assign ready_o = (ph_q == PH_IDLE);
  assign done_o  = (ph_q == PH_TI)
                 || (ph_q == PH_T3 && !idle_q)
                 || (ph_q == PH_T2 && !mux_i && !idle_q);
endmodule

// File: rtl/ext_bus_idle_seq.sv
module ext_bus_idle_seq
  import ebis_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int REG_W   = 16,
  parameter int N_BLK   = 4,
  parameter int BLK_LSB = 24,
  parameter int SIZE_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mux_mode_i,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              req_write_i,
  input  logic [SIZE_W-1:0] req_size_i,
  input  logic              req_internal_i,
  output logic              req_ready_o,
  input  logic              cfg_we_i,
  input  logic [REG_W-1:0]  cfg_wdata_i,
  output logic [REG_W-1:0]  cfg_rdata_o,
  output logic [2:0]        bus_phase_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic              bus_write_o,
  output logic [SIZE_W-1:0] bus_size_o,
  output logic              bus_rd_o,
  output logic              bus_wr_o,
  output logic              done_o
);
  logic             mode_q;
  logic [N_BLK-1:0] idle_en;
  logic             idle_req;
  logic             start;
  bus_phase_e       phase;

  // mode follows the pin only while reset is held
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= mux_mode_i;
    else         mode_q <= mode_q;
  end

  assign start = req_valid_i && !req_internal_i && req_ready_o;

  ebis_cfg_reg #(.REG_W(REG_W), .N_BLK(N_BLK)) i_cfg (
    .clk_i, .rst_ni,
    .we_i      (cfg_we_i),
    .wdata_i   (cfg_wdata_i),
    .rdata_o   (cfg_rdata_o),
    .idle_en_o (idle_en)
  );

  ebis_blk_dec #(.ADDR_W(ADDR_W), .N_BLK(N_BLK), .BLK_LSB(BLK_LSB)) i_dec (
    .addr_i     (req_addr_i),
    .write_i    (req_write_i),
    .idle_en_i  (idle_en),
    .idle_req_o (idle_req)
  );

  ebis_seq i_seq (
    .clk_i, .rst_ni,
    .mux_i      (mode_q),
    .start_i    (start),
    .idle_req_i (idle_req),
    .phase_o    (phase),
    .ready_o    (req_ready_o),
    .done_o     (done_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bus_addr_o  <= '0;
      bus_write_o <= 1'b0;
      bus_size_o  <= '0;
    end else if (start) begin
      bus_addr_o  <= req_addr_i;
      bus_write_o <= req_write_i;
      bus_size_o  <= req_size_i;
    end
  end

  logic strobe_ph;
  assign strobe_ph   = (phase == PH_T2) || (phase == PH_T3);
  assign bus_rd_o    = strobe_ph && !bus_write_o;
  assign bus_wr_o    = strobe_ph && bus_write_o;
  assign bus_phase_o = phase;
endmodule

// File: rtl/ebis_chk.sv
module ebis_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        mode_q,
  input logic [2:0]  bus_phase_o,
  input logic        bus_write_o,
  input logic        bus_rd_o,
  input logic        bus_wr_o,
  input logic        done_o,
  input logic        req_ready_o,
  input logic [15:0] cfg_rdata_o
);
  AST_TI_AFTER_T3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q && bus_phase_o == 3'd4) |-> $past(bus_phase_o) == 3'd3); // R1
  AST_TI_AFTER_T2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_q && bus_phase_o == 3'd4) |-> $past(bus_phase_o) == 3'd2); // R2
  AST_NO_T3_SEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_q |-> bus_phase_o != 3'd3); // R2
  AST_NO_IDLE_ON_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_phase_o == 3'd4 |-> !bus_write_o); // R3
  AST_FIXED_BITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_rdata_o & 16'hFF55) == 16'hAA00); // R6
  AST_DONE_THEN_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> req_ready_o); // R9
  AST_DONE_NOT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !req_ready_o); // R9
  AST_MODE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(mode_q)); // R10
  AST_STROBE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_rd_o && bus_wr_o)); // R11
  AST_STROBE_PHASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_rd_o || bus_wr_o) |-> (bus_phase_o == 3'd2 || bus_phase_o == 3'd3)); // R11
endmodule

bind ext_bus_idle_seq ebis_chk i_chk (
  .clk_i, .rst_ni, .mode_q, .bus_phase_o, .bus_write_o,
  .bus_rd_o, .bus_wr_o, .done_o, .req_ready_o, .cfg_rdata_o
);

// File: tb/test_ext_bus_idle_seq.sv
module test_ext_bus_idle_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mux_mode = 1'b1;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic [1:0]  req_size = '0;
  logic        req_internal = 1'b0;
  logic        req_ready;
  logic        cfg_we = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cfg_rdata;
  logic [2:0]  bus_phase;
  logic [31:0] bus_addr;
  logic        bus_write;
  logic [1:0]  bus_size;
  logic        bus_rd, bus_wr, done;

  int checks = 0;
  int failures = 0;
  logic [3:0] model_en = 4'hF;
  logic       model_mux = 1'b1;

  typedef struct {int len; bit ti; bit wr; string tag;} exp_t;
  exp_t exp_q[$];

  always #10 clk = ~clk;

  ext_bus_idle_seq i_ext_bus_idle_seq (
    .clk_i(clk), .rst_ni(rst_n), .mux_mode_i(mux_mode),
    .req_valid_i(req_valid), .req_addr_i(req_addr), .req_write_i(req_write),
    .req_size_i(req_size), .req_internal_i(req_internal), .req_ready_o(req_ready),
    .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata),
    .bus_phase_o(bus_phase), .bus_addr_o(bus_addr), .bus_write_o(bus_write),
    .bus_size_o(bus_size), .bus_rd_o(bus_rd), .bus_wr_o(bus_wr), .done_o(done)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: accumulate phases of the running cycle, compare at done
  int  cyc_len = 0;
  bit  cyc_ti = 0;
  int  prev_ph = 0;
  always @(negedge clk) begin
    if (rst_n && bus_phase != 3'd0) begin
      cyc_len++;
      if (bus_phase == 3'd4) begin
        cyc_ti = 1;
        chk(prev_ph == (model_mux ? 3 : 2), model_mux ? "R1 TI after T3" : "R2 TI after T2",
            prev_ph, model_mux ? 3 : 2);
      end
      if (bus_phase == 3'd2 || bus_phase == 3'd3)
        chk(bus_rd == !bus_write && bus_wr == bus_write, "R11 strobe", {bus_rd, bus_wr}, {!bus_write, bus_write});
      if (done) begin
        exp_t e;
        if (exp_q.size() == 0) begin
          chk(0, "R9 unexpected done", 1, 0);
        end else begin
          e = exp_q.pop_front();
          chk(cyc_len == e.len, {e.tag, " length"}, cyc_len, e.len);
          chk(cyc_ti == e.ti, {e.tag, " idle"}, cyc_ti, e.ti);
        end
        cyc_len = 0;
        cyc_ti = 0;
      end
    end
    prev_ph = bus_phase;
  end

  task automatic do_reset(input bit mode);
    @(negedge clk);
    rst_n = 1'b0;
    mux_mode = mode;
    model_mux = mode;
    model_en = 4'hF;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // driver: issue one request and push its expected shape
  task automatic issue(input logic [1:0] blk, input bit wr, input string tag);
    exp_t e;
    bit ti;
    while (!req_ready) @(negedge clk);
    ti = !wr && model_en[blk];
    e.len = (model_mux ? 3 : 2) + (ti ? 1 : 0);
    e.ti = ti;
    e.wr = wr;
    e.tag = tag;
    exp_q.push_back(e);
    req_valid = 1'b1;
    req_addr = {6'd0, blk, 24'h00_1234};
    req_write = wr;
    req_size = 2'd2;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R9 busy after accept", req_ready, 0);
    chk(bus_addr[25:24] == blk && bus_write == wr, "R8 captured request", bus_addr[25:24], blk);
    while (!req_ready) @(negedge clk);
  endtask

  task automatic cfg_write(input logic [15:0] v);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
    model_en = {v[7], v[5], v[3], v[1]};
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    do_reset(1'b1);
    @(negedge clk);
    chk(cfg_rdata == 16'hAAAA, "R5 reset value", cfg_rdata, 16'hAAAA);
    chk(req_ready && bus_phase == 0 && !done, "R9 reset idle", bus_phase, 0);

    // multiplexed mode, default register
    for (int b = 0; b < 4; b++) issue(b[1:0], 1'b0, "R1 R5 mux read");
    for (int b = 0; b < 4; b++) issue(b[1:0], 1'b1, "R3 mux write");

    // fixed bits ignored, only block 0 enabled
    cfg_write(16'h5502);
    @(negedge clk);
    chk(cfg_rdata == 16'hAA02, "R6 fixed bits", cfg_rdata, 16'hAA02);
    for (int b = 0; b < 4; b++) issue(b[1:0], 1'b0, "R4 R8 single block0");
    cfg_write(16'hAA80);
    @(negedge clk);
    chk(cfg_rdata == 16'hAA80, "R4 block3 only", cfg_rdata, 16'hAA80);
    for (int b = 0; b < 4; b++) issue(b[1:0], 1'b0, "R4 R8 single block3");

    // internal request starts nothing
    @(negedge clk);
    req_valid = 1'b1;
    req_internal = 1'b1;
    @(negedge clk);
    chk(bus_phase == 0 && req_ready, "R7 internal bypass", bus_phase, 0);
    @(negedge clk);
    req_valid = 1'b0;
    req_internal = 1'b0;
    chk(bus_phase == 0 && req_ready, "R7 internal bypass hold", bus_phase, 0);

    // separate mode
    do_reset(1'b0);
    @(negedge clk);
    chk(cfg_rdata == 16'hAAAA, "R5 reset value again", cfg_rdata, 16'hAAAA);
    issue(2'd1, 1'b0, "R2 sep read idle");
    issue(2'd2, 1'b1, "R2 R3 sep write");
    mux_mode = 1'b1;  // must not be picked up
    issue(2'd3, 1'b0, "R10 mode held read");
    issue(2'd0, 1'b1, "R10 mode held write");
    cfg_write(16'h0000);
    @(negedge clk);
    chk(cfg_rdata == 16'hAA00, "R6 zero write", cfg_rdata, 16'hAA00);
    issue(2'd1, 1'b0, "R2 R4 sep read no idle");

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R9 all cycles done", exp_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule